// File: doc/BRIEF.md
# Control Endpoint IN Transmit Controller

This block stores one outgoing packet for the control endpoint of a USB device while a control read is in its data stage. It also keeps the flags that firmware and the serial engine use to pass that packet between them. On the CPU side, firmware writes bytes or 16-bit words into a small FIFO. A separate control write marks the packet ready, and can also mark it as the last packet of the data stage.

On the token side, the serial engine reports IN tokens, host acknowledgements, timeouts, setup aborts and the end of the status stage. It pulls the stored bytes one at a time, in the order they were written. The FIFO's write position is internal and is not exposed. The token side sees only the packet length. An acknowledged or aborted packet frees the FIFO, and the next packet starts at address 0. An unacknowledged packet stays in the FIFO and is replayed from its first byte.

Top module: `ctl_in_ep`

## Requirements
- R1: After reset, `in_buf_rdy`, `data_end`, `status_stage`, `overflow` and `nak` are 0, and `pkt_len` is 0.
- R2: A byte write (`cpu_wr_en`=1, `cpu_wr_word`=0) stores `cpu_wr_data[7:0]` at the next free position and raises `pkt_len` by 1.
- R3: A word write (`cpu_wr_word`=1) stores `cpu_wr_data[7:0]` at the next free position and `cpu_wr_data[15:8]` in the position after it, and raises `pkt_len` by 2.
- R4: A write whose bytes do not all fit within DEPTH is dropped completely. It sets `overflow`, which then stays 1 until reset.
- R5: A control write with `cpu_set_rdy`=1 sets `in_buf_rdy` on the next edge. FIFO writes made while `in_buf_rdy` is 1 leave the packet unchanged.
- R6: While `in_buf_rdy` is 0, `tok_in` drives `nak` high in the same cycle. While `in_buf_rdy` is 1, `nak` stays 0 and `pkt_len` gives the byte count, which is 0 for an empty packet. `rd_data` shows the stored bytes in write order, and each `rd_pop` moves it to the next byte.
- R7: A `tok_ack` while `in_buf_rdy` is 1 clears `in_buf_rdy` and `pkt_len`. The next write lands at address 0.
- R8: A `tok_timeout` or a new `tok_in` while `in_buf_rdy` is 1 keeps the packet ready and returns `rd_data` to its first byte.
- R9: A control write with both `cpu_set_rdy` and `cpu_set_dend` sets `in_buf_rdy` and `data_end`. Acknowledging that packet raises `status_stage`.
- R10: `status_done` clears `data_end` and `status_stage` only while `status_stage` is 1. At other times it has no effect.
- R11: `setup_end` clears `in_buf_rdy`, `data_end`, `status_stage` and `pkt_len`. It overrides any control write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr_en | input | 1 | FIFO write strobe |
| cpu_wr_word | input | 1 | 1 for a 16-bit write, 0 for a byte write |
| cpu_wr_data | input | 16 | Write data; the low byte goes in first |
| cpu_ctl_wr | input | 1 | Control write strobe |
| cpu_set_rdy | input | 1 | Set-bit for the buffer-ready flag |
| cpu_set_dend | input | 1 | Set-bit for the data-end flag |
| tok_in | input | 1 | IN token received |
| tok_ack | input | 1 | Host acknowledged the packet |
| tok_timeout | input | 1 | No handshake arrived; replay the packet |
| setup_end | input | 1 | Setup abort: a new setup packet arrived |
| status_done | input | 1 | Status stage finished |
| rd_pop | input | 1 | Advance to the next stored byte |
| in_buf_rdy | output | 1 | Packet ready flag |
| data_end | output | 1 | Last packet flag |
| status_stage | output | 1 | Transfer has moved to the status stage |
| overflow | output | 1 | Sticky flag for a dropped write |
| nak | output | 1 | Answer to the IN token is NAK |
| pkt_len | output | clog2(DEPTH+1) | Byte count of the stored packet |
| rd_data | output | 8 | Byte at the current read position |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a setup abort and a firmware control write that sets the ready and last-packet bits. The bench drives both strobes on one edge and expects both flags to read 0 afterwards. The second pair is a FIFO write and an acknowledgement of the buffered packet. The bench judges this case at the ports: the following packet length must be exactly the number of bytes written after the acknowledgement, and its first byte must come back from address 0.

// File: rtl/ctl_in_ep.sv
module ctl_in_ep #(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_wr_en,
  input  logic                         cpu_wr_word,
  input  logic [15:0]                  cpu_wr_data,
  input  logic                         cpu_ctl_wr,
  input  logic                         cpu_set_rdy,
  input  logic                         cpu_set_dend,
  input  logic                         tok_in,
  input  logic                         tok_ack,
  input  logic                         tok_timeout,
  input  logic                         setup_end,
  input  logic                         status_done,
  input  logic                         rd_pop,
  output logic                         in_buf_rdy,
  output logic                         data_end,
  output logic                         status_stage,
  output logic                         overflow,
  output logic                         nak,
  output logic [$clog2(DEPTH+1)-1:0]   pkt_len,
  output logic [7:0]                   rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] wptr, rptr;
  logic [LW:0]   need;
  logic          fits, wr_ok, ack_ok;
  logic [AW-1:0] wa0, wa1;

  assign need   = {1'b0, wptr} + (cpu_wr_word ? (LW+1)'(2) : (LW+1)'(1));
  assign fits   = need <= (LW+1)'(DEPTH);
  assign wr_ok  = cpu_wr_en && !in_buf_rdy && !setup_end && fits;
  assign ack_ok = tok_ack && in_buf_rdy;
  assign wa0    = AW'(wptr);
  assign wa1    = AW'(wptr + LW'(1));

  assign nak     = tok_in && !in_buf_rdy;
  assign pkt_len = wptr;
  assign rd_data = mem[AW'(rptr)];

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wa0] <= cpu_wr_data[7:0];
      if (cpu_wr_word) mem[wa1] <= cpu_wr_data[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      overflow <= 1'b0;
    else if (cpu_wr_en && !in_buf_rdy && !setup_end && !fits)
      overflow <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_buf_rdy   <= 1'b0;
      data_end     <= 1'b0;
      status_stage <= 1'b0;
      wptr         <= '0;
      rptr         <= '0;
    end else if (setup_end) begin
      in_buf_rdy   <= 1'b0;
      data_end     <= 1'b0;
      status_stage <= 1'b0;
      wptr         <= '0;
      rptr         <= '0;
    end else begin
      if (wr_ok) wptr <= need[LW-1:0];
      if (cpu_ctl_wr && cpu_set_rdy)  in_buf_rdy <= 1'b1;
      if (cpu_ctl_wr && cpu_set_dend) data_end   <= 1'b1;
      if (ack_ok) begin
        in_buf_rdy <= 1'b0;
        wptr       <= '0;
        rptr       <= '0;
        if (data_end) status_stage <= 1'b1;
      end else if (tok_in || tok_timeout) begin
        rptr <= '0;
      end else if (rd_pop && in_buf_rdy && rptr < wptr) begin
        rptr <= rptr + LW'(1);
      end
      if (status_done && status_stage) begin
        data_end     <= 1'b0;
        status_stage <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctl_in_ep_chk.sv
module ctl_in_ep_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cpu_wr_en,
  input logic                       cpu_ctl_wr,
  input logic                       cpu_set_rdy,
  input logic                       cpu_set_dend,
  input logic                       tok_in,
  input logic                       tok_ack,
  input logic                       setup_end,
  input logic                       status_done,
  input logic                       in_buf_rdy,
  input logic                       data_end,
  input logic                       status_stage,
  input logic                       overflow,
  input logic                       nak,
  input logic [$clog2(DEPTH+1)-1:0] pkt_len
);
  localparam int LW = $clog2(DEPTH + 1);

  // R1
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) pkt_len <= LW'(DEPTH));
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !in_buf_rdy && !setup_end && pkt_len == LW'(DEPTH)) |=> overflow);
  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  // R5
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_buf_rdy) |-> $past(cpu_ctl_wr && cpu_set_rdy));
  // R5
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_buf_rdy && !tok_ack && !setup_end) |=> $stable(pkt_len));
  // R6
  nak_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && in_buf_rdy) |-> !nak);
  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_ack && in_buf_rdy && !setup_end && !cpu_ctl_wr) |=> (!in_buf_rdy && pkt_len == '0));
  // R9
  status_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_ack && in_buf_rdy && data_end && !setup_end) |=> status_stage);
  // R10
  status_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_done && status_stage && !setup_end && !cpu_ctl_wr) |=> (!data_end && !status_stage));
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_end |=> (!in_buf_rdy && !data_end && !status_stage && pkt_len == '0));
endmodule

bind ctl_in_ep ctl_in_ep_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_ctl_wr(cpu_ctl_wr),
  .cpu_set_rdy(cpu_set_rdy), .cpu_set_dend(cpu_set_dend), .tok_in(tok_in),
  .tok_ack(tok_ack), .setup_end(setup_end), .status_done(status_done),
  .in_buf_rdy(in_buf_rdy), .data_end(data_end), .status_stage(status_stage),
  .overflow(overflow), .nak(nak), .pkt_len(pkt_len)
);

// File: tb/tb_ctl_in_ep.sv
`timescale 1ns/1ps
module tb_ctl_in_ep;
  localparam int DEPTH = 8;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic cpu_wr_en = 0, cpu_wr_word = 0, cpu_ctl_wr = 0, cpu_set_rdy = 0, cpu_set_dend = 0;
  logic [15:0] cpu_wr_data = 0;
  logic tok_in = 0, tok_ack = 0, tok_timeout = 0, setup_end = 0, status_done = 0, rd_pop = 0;
  logic in_buf_rdy, data_end, status_stage, overflow, nak;
  logic [LW-1:0] pkt_len;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q [DEPTH];

  always #10 clk = ~clk;

  ctl_in_ep #(.DEPTH(DEPTH)) dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    cpu_wr_en = 1; cpu_wr_word = 0; cpu_wr_data = {8'h00, d};
    tick(); cpu_wr_en = 0;
  endtask

  task automatic wr_word(input logic [15:0] d);
    cpu_wr_en = 1; cpu_wr_word = 1; cpu_wr_data = d;
    tick(); cpu_wr_en = 0; cpu_wr_word = 0;
  endtask

  task automatic ctl(input bit r, input bit e);
    cpu_ctl_wr = 1; cpu_set_rdy = r; cpu_set_dend = e;
    tick(); cpu_ctl_wr = 0; cpu_set_rdy = 0; cpu_set_dend = 0;
  endtask

  task automatic in_token(output bit n);
    tok_in = 1; #1; n = nak;
    tick(); tok_in = 0;
  endtask

  task automatic pulse_ack();     tok_ack = 1;     tick(); tok_ack = 0;     endtask
  task automatic pulse_timeout(); tok_timeout = 1; tick(); tok_timeout = 0; endtask
  task automatic pulse_abort();   setup_end = 1;   tick(); setup_end = 0;   endtask
  task automatic pulse_sdone();   status_done = 1; tick(); status_done = 0; endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      check(rd_data == exp_q[i], tag, rd_data, exp_q[i]);
      rd_pop = 1; tick(); rd_pop = 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit n;
    #35 rst_n = 1; tick();
    // R1
    check(!in_buf_rdy && !data_end && !status_stage && !overflow, "R1 flags", in_buf_rdy, 0);
    check(pkt_len == 0, "R1 len", pkt_len, 0);

    // R6 nak while idle
    in_token(n);
    check(n == 1, "R6 nak idle", n, 1);

    // byte sweep over every length
    for (int len = 0; len <= DEPTH; len++) begin
      for (int i = 0; i < len; i++) begin
        exp_q[i] = 8'((len * 16 + i * 3 + 1) & 255);
        wr_byte(exp_q[i]);
      end
      check(pkt_len == LW'(len), "R2 byte len", pkt_len, len);
      if (len == DEPTH) begin
        wr_byte(8'hEE);
        check(pkt_len == LW'(DEPTH), "R4 full byte dropped", pkt_len, DEPTH);
        check(overflow == 1, "R4 overflow set", overflow, 1);
      end
      ctl(1, 0);
      check(in_buf_rdy == 1, "R5 rdy set", in_buf_rdy, 1);
      wr_byte(8'h5A);
      check(pkt_len == LW'(len), "R5 write while ready ignored", pkt_len, len);
      in_token(n);
      check(n == 0, "R6 no nak when ready", n, 0);
      drain(len, "R6 stream");
      pulse_timeout();
      check(in_buf_rdy == 1, "R8 rdy kept", in_buf_rdy, 1);
      if (len > 0) check(rd_data == exp_q[0], "R8 replay first", rd_data, exp_q[0]);
      in_token(n);
      drain(len, "R8 replay stream");
      pulse_ack();
      check(!in_buf_rdy && pkt_len == 0, "R7 ack release", pkt_len, 0);
    end
    check(overflow == 1, "R4 sticky", overflow, 1);

    // word sweep with a leading byte offset
    for (int off = 0; off < 2; off++) begin
      for (int w = 0; 2 * w + off <= DEPTH; w++) begin
        int p;
        p = 0;
        if (off == 1) begin exp_q[0] = 8'hA0; wr_byte(8'hA0); p = 1; end
        for (int i = 0; i < w; i++) begin
          logic [15:0] d;
          d = 16'((w * 4096) + (i * 257) + 16'h1234);
          exp_q[p] = d[7:0]; exp_q[p+1] = d[15:8];
          wr_word(d);
          p += 2;
        end
        check(pkt_len == LW'(p), "R3 word len", pkt_len, p);
        if (p == DEPTH - 1) begin
          wr_word(16'hBEEF);
          check(pkt_len == LW'(p), "R4 word straddle dropped", pkt_len, p);
        end
        ctl(1, 0);
        in_token(n);
        drain(p, "R3 word order");
        pulse_ack();
      end
    end

    // ack with a simultaneous FIFO write: next packet from address 0
    wr_byte(8'h11); ctl(1, 0);
    tok_ack = 1; cpu_wr_en = 1; cpu_wr_data = 16'h0077; tick();
    tok_ack = 0; cpu_wr_en = 0;
    check(pkt_len == 0, "R7 write during ack ignored", pkt_len, 0);
    exp_q[0] = 8'h33; wr_byte(8'h33); ctl(1, 0);
    check(pkt_len == 1 && rd_data == 8'h33, "R7 restart at 0", rd_data, 8'h33);
    pulse_ack();

    // last packet and status stage
    pulse_sdone();
    ctl(1, 1);
    check(in_buf_rdy && data_end, "R9 both flags", data_end, 1);
    pulse_sdone();
    check(data_end == 1, "R10 early status_done ignored", data_end, 1);
    check(pkt_len == 0, "R6 empty packet len", pkt_len, 0);
    pulse_ack();
    check(status_stage == 1 && !in_buf_rdy, "R9 status stage", status_stage, 1);
    pulse_sdone();
    check(!status_stage && !data_end, "R10 status exit", data_end, 0);

    // setup abort
    wr_byte(8'h44); ctl(1, 1);
    pulse_abort();
    check(!in_buf_rdy && !data_end && pkt_len == 0, "R11 abort", in_buf_rdy, 0);
    setup_end = 1; cpu_ctl_wr = 1; cpu_set_rdy = 1; cpu_set_dend = 1; tick();
    setup_end = 0; cpu_ctl_wr = 0; cpu_set_rdy = 0; cpu_set_dend = 0;
    check(!in_buf_rdy && !data_end, "R11 abort beats set", in_buf_rdy, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule